// File: doc/BRIEF.md
# Virtual LPI Routing Lookup Unit

This block turns a translated interrupt that targets a virtual processing element into a delivery request for a redistributor. Each incoming command names a vPE, a virtual interrupt ID, a doorbell interrupt number and a level. The unit reads that vPE's 64-bit descriptor from memory. It then checks the descriptor, the target redistributor and the interrupt ID. The outcome is either one dispatch beat plus an OK result, or a result alone that tells the command queue to drop the command (CONTINUE) or to hold it (STALL).

The descriptor table can be a flat array or a two-level structure. In the flat case, entry N sits at the table base plus 8·N. In the two-level case, a first-level word selects a page of `PAGE_ENTRIES` descriptors. Memory words arrive as 64-bit little-endian values, so byte 0 lands in bits 7:0. The unit handles one command at a time.

Back-pressure rules:
- The command port accepts a command on a cycle where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` is high only while the unit is idle.
- The memory request channel is valid/ready. A request holds its address until it is accepted.
- Responses are never back-pressured.
- The result and dispatch outputs are single-cycle strobes with no ready.

Top module: `vlpi_route_unit`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in progress. After a command is accepted, `cmd_ready` stays low until its result strobe has been given, and no memory request is raised while idle.
- R2: A vPE ID greater than or equal to `cfg_num_vpe` yields result CONTINUE (code 1) with no memory request.
- R3: With `cfg_two_level` low, exactly one read is made, at `cfg_tbl_base + 8·vpeid`. While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold.
- R4: Two-level walk, with `cfg_two_level` high:
  - The first read is at `cfg_tbl_base + 8·(vpeid / PAGE_ENTRIES)`.
  - If bit 63 of that word is clear, the result is CONTINUE and no second read is made.
  - Otherwise the second read is at `word[62:0] + 8·(vpeid mod PAGE_ENTRIES)`.
- R5: An error response on either read yields result STALL (code 2) and no dispatch.
- R6: A descriptor with bit 63 (valid) clear yields CONTINUE.
- R7: A redistributor index (descriptor bits 23:5) greater than or equal to `NUM_CPU` yields CONTINUE.
- R8: The interrupt ID must satisfy both of the following, otherwise the result is CONTINUE:
  - it is at least 8192;
  - it is strictly below 2^(size+1), where size is descriptor bits 4:0.
- R9: On success the result is OK (code 0), given in the same cycle as a one-cycle `disp_valid`. The dispatch carries:
  - the redistributor index;
  - the interrupt ID;
  - the doorbell and the level from the command;
  - `disp_pt_addr` = descriptor bits 62:24 shifted left by 16.
- R10: `disp_db_en` is low when the doorbell number is 1023 and high for any other doorbell number.
- R11: Every accepted command produces exactly one `res_valid` pulse lasting one cycle. `disp_valid` is never high without an OK result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbl_base | input | 64 | Byte address of the flat table or of the first-level table |
| cfg_num_vpe | input | VPE_ID_W+1 | Number of valid vPE IDs |
| cfg_two_level | input | 1 | Selects the two-level table walk |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted on this cycle if valid |
| cmd_vpeid | input | VPE_ID_W | Target vPE ID |
| cmd_intid | input | 32 | Virtual interrupt ID |
| cmd_doorbell | input | 32 | Doorbell interrupt number, 1023 for none |
| cmd_level | input | 1 | Level to apply |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the 64-bit word to read |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Read data, little-endian word |
| mem_rsp_err | input | 1 | Read failed |
| res_valid | output | 1 | Result strobe |
| res_code | output | 2 | 0 OK, 1 CONTINUE, 2 STALL |
| disp_valid | output | 1 | Dispatch strobe to the redistributor |
| disp_rd | output | CPU_W | Target redistributor index |
| disp_intid | output | 32 | Interrupt ID |
| disp_pt_addr | output | 55 | Pending-table byte address |
| disp_doorbell | output | 32 | Doorbell number |
| disp_db_en | output | 1 | A doorbell is requested |
| disp_level | output | 1 | Level |

## Verification
The bench builds the unit with `NUM_CPU` = 4, `VPE_ID_W` = 8 and `PAGE_ENTRIES` = 4. With four CPUs, the accepted index 3 and the rejected index 4 both sit in small descriptors. With four descriptors per page, vPE IDs below 16 already span several first-level words, so first-level index and in-page offset are both exercised. The bench also reaches the interrupt-ID edges 8191/8192 and 16383/16384 for a size field of 13, and it holds off `mem_req_ready` to show the request is held while stalled.

// File: rtl/vlpi_pkg.sv
package vlpi_pkg;

  // Descriptor layout: {valid[63], pt_field[62:24], rd_index[23:5], size[4:0]}
  localparam int SIZE_W     = 5;
  localparam int RDX_W      = 19;
  localparam int PTF_W      = 39;
  localparam int PT_SHIFT   = 16;
  localparam int PT_ADDR_W  = PTF_W + PT_SHIFT;
  localparam int IID_W      = 32;
  localparam int LPI_BASE   = 8192;
  localparam int DB_NONE    = 1023;

  typedef struct packed {
    logic             valid;
    logic [PTF_W-1:0] pt_field;
    logic [RDX_W-1:0] rd_index;
    logic [SIZE_W-1:0] size;
  } vpe_desc_t;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_CONT  = 2'd1,
    RES_STALL = 2'd2
  } res_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RANGE,
    ST_L1_REQ,
    ST_L1_RSP,
    ST_L2_REQ,
    ST_L2_RSP,
    ST_RESULT
  } walk_state_e;

endpackage

// File: rtl/vlpi_addr_gen.sv
module vlpi_addr_gen
  #(parameter int VPE_ID_W     = 16,
    parameter int PAGE_ENTRIES = 512)
  (input  logic [63:0]         base,
   input  logic [VPE_ID_W-1:0] vpeid,
   input  logic [63:0]         l1_word,
   output logic [63:0]         flat_addr,
   output logic [63:0]         l1_addr,
   output logic [63:0]         l2_addr,
   output logic                l1_present);

  localparam int PG_W = (PAGE_ENTRIES > 1) ? $clog2(PAGE_ENTRIES) : 1;

  logic [VPE_ID_W-1:0] page_idx;
  logic [PG_W-1:0]     slot_idx;

  always_comb begin
    page_idx   = vpeid >> PG_W;
    slot_idx   = vpeid[PG_W-1:0];
    flat_addr  = base + 64'({vpeid, 3'b000});
    l1_addr    = base + 64'({page_idx, 3'b000});
    l2_addr    = {1'b0, l1_word[62:0]} + 64'({slot_idx, 3'b000});
    l1_present = l1_word[63];
  end

endmodule

// File: rtl/vlpi_entry_check.sv
module vlpi_entry_check
  import vlpi_pkg::*;
  #(parameter int NUM_CPU = 8,
    parameter int CPU_W   = 3)
  (input  logic [63:0]          word,
   input  logic [IID_W-1:0]     intid,
   output res_code_e            code,
   output logic [CPU_W-1:0]     rd,
   output logic [PT_ADDR_W-1:0] pt_addr);

  vpe_desc_t   d;
  logic [32:0] id_limit;
  logic        rd_ok;
  logic        id_ok;

  always_comb begin
    d        = vpe_desc_t'(word);
    id_limit = 33'd1 << (6'(d.size) + 6'd1);
    rd_ok    = 32'(d.rd_index) < 32'(NUM_CPU);
    id_ok    = (intid >= 32'(LPI_BASE)) && ({1'b0, intid} < id_limit);
    if (!d.valid)      code = RES_CONT;
    else if (!rd_ok)   code = RES_CONT;
    else if (!id_ok)   code = RES_CONT;
    else               code = RES_OK;
    rd       = d.rd_index[CPU_W-1:0];
    pt_addr  = {d.pt_field, {PT_SHIFT{1'b0}}};
  end

endmodule

// File: rtl/vlpi_route_unit.sv
module vlpi_route_unit
  import vlpi_pkg::*;
  #(parameter int NUM_CPU      = 8,
    parameter int VPE_ID_W     = 16,
    parameter int PAGE_ENTRIES = 512,
    localparam int CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1)
  (input  logic                 clk,
   input  logic                 rst_n,
   input  logic [63:0]          cfg_tbl_base,
   input  logic [VPE_ID_W:0]    cfg_num_vpe,
   input  logic                 cfg_two_level,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic [VPE_ID_W-1:0]  cmd_vpeid,
   input  logic [31:0]          cmd_intid,
   input  logic [31:0]          cmd_doorbell,
   input  logic                 cmd_level,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [63:0]          mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [63:0]          mem_rsp_data,
   input  logic                 mem_rsp_err,
   output logic                 res_valid,
   output logic [1:0]           res_code,
   output logic                 disp_valid,
   output logic [CPU_W-1:0]     disp_rd,
   output logic [31:0]          disp_intid,
   output logic [54:0]          disp_pt_addr,
   output logic [31:0]          disp_doorbell,
   output logic                 disp_db_en,
   output logic                 disp_level);

  walk_state_e          st_q;
  logic [VPE_ID_W-1:0]  vpeid_q;
  logic [31:0]          intid_q;
  logic [31:0]          db_q;
  logic                 lvl_q;
  logic [63:0]          addr_q;
  res_code_e            code_q;
  logic [CPU_W-1:0]     rd_q;
  logic [PT_ADDR_W-1:0] pt_q;

  logic [63:0]          flat_addr;
  logic [63:0]          l1_addr;
  logic [63:0]          l2_addr;
  logic                 l1_present;
  res_code_e            chk_code;
  logic [CPU_W-1:0]     chk_rd;
  logic [PT_ADDR_W-1:0] chk_pt;

  vlpi_addr_gen #(.VPE_ID_W(VPE_ID_W), .PAGE_ENTRIES(PAGE_ENTRIES)) u_addr (
    .base       (cfg_tbl_base),
    .vpeid      (vpeid_q),
    .l1_word    (mem_rsp_data),
    .flat_addr  (flat_addr),
    .l1_addr    (l1_addr),
    .l2_addr    (l2_addr),
    .l1_present (l1_present));

  vlpi_entry_check #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_check (
    .word    (mem_rsp_data),
    .intid   (intid_q),
    .code    (chk_code),
    .rd      (chk_rd),
    .pt_addr (chk_pt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      vpeid_q <= '0;
      intid_q <= '0;
      db_q    <= '0;
      lvl_q   <= 1'b0;
      addr_q  <= '0;
      code_q  <= RES_OK;
      rd_q    <= '0;
      pt_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            vpeid_q <= cmd_vpeid;
            intid_q <= cmd_intid;
            db_q    <= cmd_doorbell;
            lvl_q   <= cmd_level;
            st_q    <= ST_RANGE;
          end
        end
        ST_RANGE: begin
          if ({1'b0, vpeid_q} >= cfg_num_vpe) begin
            code_q <= RES_CONT;
            st_q   <= ST_RESULT;
          end else if (cfg_two_level) begin
            addr_q <= l1_addr;
            st_q   <= ST_L1_REQ;
          end else begin
            addr_q <= flat_addr;
            st_q   <= ST_L2_REQ;
          end
        end
        ST_L1_REQ: if (mem_req_ready) st_q <= ST_L1_RSP;
        ST_L1_RSP: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              code_q <= RES_STALL;
              st_q   <= ST_RESULT;
            end else if (!l1_present) begin
              code_q <= RES_CONT;
              st_q   <= ST_RESULT;
            end else begin
              addr_q <= l2_addr;
              st_q   <= ST_L2_REQ;
            end
          end
        end
        ST_L2_REQ: if (mem_req_ready) st_q <= ST_L2_RSP;
        ST_L2_RSP: begin
          if (mem_rsp_valid) begin
            code_q <= mem_rsp_err ? RES_STALL : chk_code;
            rd_q   <= chk_rd;
            pt_q   <= chk_pt;
            st_q   <= ST_RESULT;
          end
        end
        ST_RESULT: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready     = (st_q == ST_IDLE);
    mem_req_valid = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
    mem_req_addr  = addr_q;
    res_valid     = (st_q == ST_RESULT);
    res_code      = code_q;
    disp_valid    = (st_q == ST_RESULT) && (code_q == RES_OK);
    disp_rd       = rd_q;
    disp_intid    = intid_q;
    disp_pt_addr  = pt_q;
    disp_doorbell = db_q;
    disp_db_en    = (db_q != 32'(DB_NONE));
    disp_level    = lvl_q;
  end

endmodule

// File: rtl/vlpi_route_unit_chk.sv
module vlpi_route_unit_chk
  #(parameter int CPU_W = 3)
  (input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [63:0]      mem_req_addr,
   input logic             mem_rsp_valid,
   input logic             mem_rsp_err,
   input logic             res_valid,
   input logic [1:0]       res_code,
   input logic             disp_valid,
   input logic [31:0]      disp_intid);

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_err_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_err |=> res_valid && res_code == 2'd2 && !disp_valid);

  assert_disp_lpi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_intid >= 32'd8192);

  assert_disp_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> res_valid && res_code == 2'd0);

  assert_res_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_code != 2'd3);

endmodule

bind vlpi_route_unit vlpi_route_unit_chk #(.CPU_W(CPU_W)) u_route_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_err   (mem_rsp_err),
  .res_valid     (res_valid),
  .res_code      (res_code),
  .disp_valid    (disp_valid),
  .disp_intid    (disp_intid));

// File: tb/test_vlpi_route_unit.sv
module test_vlpi_route_unit;

  localparam int NCPU = 4;
  localparam int VW   = 8;
  localparam int PE   = 4;
  localparam int LAT  = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cfg_tbl_base;
  logic [VW:0] cfg_num_vpe;
  logic        cfg_two_level;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [VW-1:0] cmd_vpeid;
  logic [31:0] cmd_intid;
  logic [31:0] cmd_doorbell;
  logic        cmd_level;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        mem_rsp_err;
  logic        res_valid;
  logic [1:0]  res_code;
  logic        disp_valid;
  logic [1:0]  disp_rd;
  logic [31:0] disp_intid;
  logic [54:0] disp_pt_addr;
  logic [31:0] disp_doorbell;
  logic        disp_db_en;
  logic        disp_level;

  always #4 clk = ~clk;

  vlpi_route_unit #(.NUM_CPU(NCPU), .VPE_ID_W(VW), .PAGE_ENTRIES(PE)) i_vlpi_route_unit (
    .clk, .rst_n, .cfg_tbl_base, .cfg_num_vpe, .cfg_two_level,
    .cmd_valid, .cmd_ready, .cmd_vpeid, .cmd_intid, .cmd_doorbell, .cmd_level,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err,
    .res_valid, .res_code, .disp_valid, .disp_rd, .disp_intid,
    .disp_pt_addr, .disp_doorbell, .disp_db_en, .disp_level);

  // Memory model
  logic [63:0] mem_arr [256];
  logic [63:0] err_addr;
  logic        ready_en;
  logic [63:0] pend_addr;
  int          pend_cnt;
  logic [31:0] req_count;
  logic [63:0] req_log [16];

  assign mem_req_ready = ready_en;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      pend_cnt  <= 0;
      req_count <= '0;
    end else if (pend_cnt > 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_arr[pend_addr[10:3]];
        mem_rsp_err   <= (pend_addr == err_addr);
      end
    end else if (mem_req_valid && mem_req_ready) begin
      pend_addr                <= mem_req_addr;
      pend_cnt                 <= LAT;
      req_log[req_count[3:0]]  <= mem_req_addr;
      req_count                <= req_count + 1;
    end
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic v, input logic [38:0] ptf,
                                          input logic [18:0] rd, input logic [4:0] sz);
    return {v, ptf, rd, sz};
  endfunction

  // Captured results of the last command
  logic [1:0]  g_code;
  logic        g_disp, g_dben, g_lvl, g_busy, g_pulse_ok;
  logic [1:0]  g_rd;
  logic [31:0] g_intid, g_db;
  logic [54:0] g_pt;
  int          g_nreq;
  logic [63:0] g_a0, g_a1;

  task automatic run_cmd(input logic [VW-1:0] vp, input logic [31:0] iid,
                         input logic [31:0] db, input logic lv);
    logic [31:0] base;
    int w;
    base = req_count;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_vpeid = vp; cmd_intid = iid; cmd_doorbell = db; cmd_level = lv;
    @(negedge clk);
    cmd_valid = 1'b0;
    g_busy = !cmd_ready;
    w = 0;
    while (!res_valid && w < 300) begin
      @(negedge clk);
      w++;
    end
    g_code = res_code; g_disp = disp_valid; g_rd = disp_rd; g_intid = disp_intid;
    g_pt = disp_pt_addr; g_db = disp_doorbell; g_dben = disp_db_en; g_lvl = disp_level;
    g_nreq = int'(req_count - base);
    g_a0 = req_log[base[3:0]];
    g_a1 = req_log[4'(base[3:0] + 4'd1)];
    @(negedge clk);
    g_pulse_ok = !res_valid;
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1", "ready after reset", 64'(cmd_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1", "no request after reset", 64'(mem_req_valid), 64'd0);
    chk(res_valid == 1'b0 && disp_valid == 1'b0, "R11", "no strobes after reset",
        64'({res_valid, disp_valid}), 64'd0);
  endtask

  task automatic t_flat_ok();
    cfg_two_level = 1'b0;
    mem_arr[8'h23] = mk_desc(1'b1, 39'h12345, 19'd2, 5'd15);
    run_cmd(8'd3, 32'd9000, 32'd50, 1'b1);
    chk(g_busy, "R1", "busy after accept", 64'(g_busy), 64'd1);
    chk(g_nreq == 1 && g_a0 == 64'h118, "R3", "flat read address", g_a0, 64'h118);
    chk(g_code == 2'd0 && g_disp, "R9", "ok with dispatch", 64'({g_disp, g_code}), 64'h4);
    chk(g_rd == 2'd2, "R9", "rd index", 64'(g_rd), 64'd2);
    chk(g_intid == 32'd9000 && g_lvl, "R9", "intid/level", 64'(g_intid), 64'd9000);
    chk(g_pt == 55'h12345_0000, "R9", "pending table addr", 64'(g_pt), 64'h123450000);
    chk(g_db == 32'd50 && g_dben, "R10", "doorbell enabled", 64'({g_dben, g_db}), 64'h100000032);
    chk(g_pulse_ok, "R11", "result pulse one cycle", 64'(g_pulse_ok), 64'd1);
  endtask

  task automatic t_vpe_range();
    mem_arr[8'h2F] = mk_desc(1'b1, 39'h7, 19'd1, 5'd20);
    run_cmd(8'd15, 32'd8192, 32'd7, 1'b0);
    chk(g_code == 2'd0 && g_a0 == 64'h178, "R2", "last valid vpe id", g_a0, 64'h178);
    run_cmd(8'd16, 32'd8192, 32'd7, 1'b0);
    chk(g_code == 2'd1 && !g_disp, "R2", "vpe id at limit drops", 64'(g_code), 64'd1);
    chk(g_nreq == 0, "R2", "no memory read", 64'(g_nreq), 64'd0);
  endtask

  task automatic t_invalid_desc();
    mem_arr[8'h24] = mk_desc(1'b0, 39'h5, 19'd0, 5'd20);
    run_cmd(8'd4, 32'd9000, 32'd1, 1'b1);
    chk(g_code == 2'd1 && !g_disp, "R6", "invalid descriptor", 64'(g_code), 64'd1);
  endtask

  task automatic t_rd_bound();
    mem_arr[8'h25] = mk_desc(1'b1, 39'h5, 19'd4, 5'd20);
    run_cmd(8'd5, 32'd9000, 32'd1, 1'b1);
    chk(g_code == 2'd1 && !g_disp, "R7", "rd index equal to cpu count", 64'(g_code), 64'd1);
    mem_arr[8'h25] = mk_desc(1'b1, 39'h5, 19'd3, 5'd20);
    run_cmd(8'd5, 32'd9000, 32'd1, 1'b1);
    chk(g_code == 2'd0 && g_rd == 2'd3, "R7", "highest rd index", 64'(g_rd), 64'd3);
  endtask

  task automatic t_intid_bounds();
    mem_arr[8'h26] = mk_desc(1'b1, 39'h9, 19'd1, 5'd13);
    run_cmd(8'd6, 32'd8191, 32'd1, 1'b0);
    chk(g_code == 2'd1, "R8", "below lpi range", 64'(g_code), 64'd1);
    run_cmd(8'd6, 32'd16383, 32'd1, 1'b0);
    chk(g_code == 2'd0 && g_intid == 32'd16383, "R8", "top of table size", 64'(g_code), 64'd0);
    run_cmd(8'd6, 32'd16384, 32'd1, 1'b0);
    chk(g_code == 2'd1 && !g_disp, "R8", "beyond table size", 64'(g_code), 64'd1);
  endtask

  task automatic t_no_doorbell();
    run_cmd(8'd6, 32'd8192, 32'd1023, 1'b1);
    chk(g_code == 2'd0 && !g_dben && g_db == 32'd1023, "R10", "doorbell 1023 disabled",
        64'(g_dben), 64'd0);
  endtask

  task automatic t_mem_error();
    mem_arr[8'h27] = mk_desc(1'b1, 39'h9, 19'd1, 5'd20);
    err_addr = 64'h138;
    run_cmd(8'd7, 32'd9000, 32'd1, 1'b0);
    chk(g_code == 2'd2 && !g_disp, "R5", "flat read error stalls", 64'(g_code), 64'd2);
    err_addr = '1;
  endtask

  task automatic t_two_level();
    cfg_two_level = 1'b1;
    cfg_tbl_base  = 64'h200;
    mem_arr[8'h41] = {1'b1, 63'h400};
    mem_arr[8'h82] = mk_desc(1'b1, 39'hABC, 19'd1, 5'd16);
    run_cmd(8'd6, 32'd10000, 32'd33, 1'b1);
    chk(g_nreq == 2 && g_a0 == 64'h208, "R4", "first-level address", g_a0, 64'h208);
    chk(g_a1 == 64'h410, "R4", "second-level address", g_a1, 64'h410);
    chk(g_code == 2'd0 && g_pt == 55'hABC_0000, "R4", "two-level dispatch", 64'(g_pt), 64'hABC0000);
    mem_arr[8'h42] = 64'h0;
    run_cmd(8'd9, 32'd10000, 32'd33, 1'b1);
    chk(g_code == 2'd1 && g_nreq == 1, "R4", "absent page drops", 64'(g_nreq), 64'd1);
    err_addr = 64'h218;
    run_cmd(8'd13, 32'd10000, 32'd33, 1'b1);
    chk(g_code == 2'd2 && !g_disp && g_nreq == 1, "R5", "first-level error stalls",
        64'(g_code), 64'd2);
    err_addr = '1;
    cfg_two_level = 1'b0;
    cfg_tbl_base  = 64'h100;
  endtask

  task automatic t_backpressure();
    ready_en = 1'b0;
    fork
      run_cmd(8'd3, 32'd9000, 32'd50, 1'b0);
      begin
        repeat (5) @(negedge clk);
        chk(mem_req_valid && mem_req_addr == 64'h118, "R3", "request held while stalled",
            mem_req_addr, 64'h118);
        ready_en = 1'b1;
      end
    join
    chk(g_nreq == 1 && g_code == 2'd0, "R3", "single read after back-pressure",
        64'(g_nreq), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = 64'h0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_vpeid = '0; cmd_intid = '0;
    cmd_doorbell = '0; cmd_level = 1'b0; ready_en = 1'b1; err_addr = '1;
    cfg_tbl_base = 64'h100; cfg_num_vpe = 9'd16; cfg_two_level = 1'b0;
    mem_rsp_data = '0; mem_rsp_err = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat_ok();
    t_vpe_range();
    t_invalid_desc();
    t_rd_bound();
    t_intid_bounds();
    t_no_doorbell();
    t_mem_error();
    t_two_level();
    t_backpressure();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule